// File: doc/BRIEF.md
# Next-PC Target Unit

This block picks the address of the next instruction for a 32-bit fixed-length instruction stream. Each cycle it takes the current program counter, the two immediate fields that decode pulls out of the instruction word (a 16-bit branch displacement and a 26-bit jump index), two register operands read from the register file, and a 4-bit control code. The control code chooses one of four target rules: fall through, a conditional compare-and-branch relative to the following instruction, a jump inside the current address region, or a jump to an address held in a register.

The result is registered. One clock after the inputs are presented, the block shows the chosen next PC, a flag that is high when control leaves the sequential path, and a link write request. The link write request names register 31 and carries the return address for the two linking jump forms. Execution is treated as strictly sequential. There is no delay slot, no fetch logic and no prediction.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, every output is held at its reset value: `nxt_pc` = RESET_PC (default 0), and `taken`, `link_we`, `link_idx` and `link_data` are all zero.
- R2: Outputs are registered. Inputs sampled at a rising clock edge appear on the outputs after that edge and hold until the next edge.
- R3: Code 0 (sequential) and the unused codes 9 to 15 give `nxt_pc` = `cur_pc`+4, `taken` = 0 and no link write.
- R4: Code 1 branches when `opa` == `opb`. Code 2 branches when `opa` != `opb`.
- R5: Code 3 branches when `opa`, read as signed, is <= 0. Code 4 branches when `opa`, read as signed, is > 0. Both codes ignore `opb`.
- R6: A taken branch gives `nxt_pc` = `cur_pc`+4 + (sign-extended `br_off` shifted left by 2) and `taken` = 1. A branch that is not taken gives `nxt_pc` = `cur_pc`+4 and `taken` = 0.
- R7: Codes 5 (jump) and 6 (jump and link) give `nxt_pc` = {bits 31:28 of `cur_pc`+4, `jmp_idx`, 2'b00} with `taken` = 1.
- R8: Codes 7 (register jump) and 8 (register jump and link) give `nxt_pc` = `opa` unchanged, including its low two bits, with `taken` = 1.
- R9: Codes 6 and 8 set `link_we` = 1, `link_idx` = 31 and `link_data` = `cur_pc`+4. Every other code gives `link_we` = 0, `link_idx` = 0 and `link_data` = 0.
- R10: All PC arithmetic wraps modulo 2^32. For example, `cur_pc` = 0xFFFFFFFC falls through to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_pc | input | 32 | Address of the current instruction |
| br_off | input | 16 | Branch displacement in instruction units |
| jmp_idx | input | 26 | Region jump index in instruction units |
| opa | input | 32 | First register operand; also the register jump target |
| opb | input | 32 | Second register operand |
| op | input | 4 | Control code (0 to 8 defined; 9 to 15 act as 0) |
| nxt_pc | output | 32 | Next program counter |
| taken | output | 1 | High when control leaves the sequential path |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Destination register of the link write |
| link_data | output | 32 | Return address to write |

## Verification
Random vectors draw every code from 0 to 15. The operand pairs are biased toward equal values, zero, and the most positive and most negative signed values, so that each compare sits on both sides of its boundary. This separates a signed test from an unsigned one, and `<=` from `<`. Directed cases cover the following:
- negative and extreme branch displacements, which catch a missing sign extension or shift;
- a PC in the top region, which shows that the region bits come from PC+4 and not from PC;
- a register target with odd low bits, which must pass through untouched;
- a PC at the top of the address space, which must wrap to zero.

Changing `opb` under the zero-compare codes shows that it has no effect on the outcome.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Control codes; values 9..15 are unused and behave as sequential
    typedef enum logic [3:0] {
        NPC_SEQ  = 4'd0,
        NPC_BEQ  = 4'd1,
        NPC_BNE  = 4'd2,
        NPC_BLEZ = 4'd3,
        NPC_BGTZ = 4'd4,
        NPC_JMP  = 4'd5,
        NPC_JAL  = 4'd6,
        NPC_JR   = 4'd7,
        NPC_JALR = 4'd8
    } npc_op_e;

    // Target source chosen by the selector
    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_BR  = 2'd1,
        SRC_RGN = 2'd2,
        SRC_REG = 2'd3
    } npc_src_e;

    function automatic npc_op_e npc_decode(input logic [3:0] raw);
        npc_op_e r;
        if (raw > 4'd8) r = NPC_SEQ;
        else            r = npc_op_e'(raw);
        return r;
    endfunction

    function automatic logic npc_is_link(input npc_op_e o);
        return (o == NPC_JAL) || (o == NPC_JALR);
    endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  npc_op_e          op,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic             is_branch,
    output logic             cond_ok
);
    logic eq;
    logic a_neg;
    logic a_zero;

    always_comb begin
        eq     = (opa == opb);
        a_neg  = opa[XLEN-1];
        a_zero = (opa == '0);
        is_branch = 1'b0;
        cond_ok   = 1'b0;
        unique case (op)
            NPC_BEQ:  begin is_branch = 1'b1; cond_ok = eq;                end
            NPC_BNE:  begin is_branch = 1'b1; cond_ok = !eq;               end
            NPC_BLEZ: begin is_branch = 1'b1; cond_ok = a_neg || a_zero;   end
            NPC_BGTZ: begin is_branch = 1'b1; cond_ok = !a_neg && !a_zero; end
            default:  begin is_branch = 1'b0; cond_ok = 1'b0;              end
        endcase
    end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26,
    parameter int STEP  = 4
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] br_off,
    input  logic [IDX_W-1:0] jmp_idx,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  br_pc,
    output logic [XLEN-1:0]  rgn_pc
);
    localparam int SH    = $clog2(STEP);
    localparam int RGN_W = XLEN - IDX_W - SH;
    localparam int EXT_W = XLEN - OFF_W - SH;

    logic [XLEN-1:0] disp;

    always_comb begin
        seq_pc = pc + XLEN'(STEP);
        disp   = {{EXT_W{br_off[OFF_W-1]}}, br_off, {SH{1'b0}}};
        br_pc  = seq_pc + disp;
    end

    generate
        if (RGN_W > 0) begin : g_region
            always_comb rgn_pc = {seq_pc[XLEN-1 -: RGN_W], jmp_idx, {SH{1'b0}}};
        end else begin : g_flat
            always_comb rgn_pc = {jmp_idx[XLEN-SH-1:0], {SH{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/npc_link.sv
module npc_link
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  npc_op_e           op,
    input  logic [XLEN-1:0]   seq_pc,
    output logic              we,
    output logic [RIDX_W-1:0] idx,
    output logic [XLEN-1:0]   data
);
    always_comb begin
        we   = npc_is_link(op);
        idx  = we ? RIDX_W'(LINK_REG) : '0;
        data = we ? seq_pc : '0;
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          OFF_W    = 16,
    parameter int          IDX_W    = 26,
    parameter int          STEP     = 4,
    parameter int          RIDX_W   = 5,
    parameter int          LINK_REG = 31,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [IDX_W-1:0]  jmp_idx,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  logic [3:0]        op,
    output logic [XLEN-1:0]   nxt_pc,
    output logic              taken,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx,
    output logic [XLEN-1:0]   link_data
);
    typedef struct packed {
        logic [XLEN-1:0]   pc;
        logic              taken;
        logic              link_we;
        logic [RIDX_W-1:0] link_idx;
        logic [XLEN-1:0]   link_data;
    } npc_state_t;

    npc_op_e          op_dec;
    logic             is_branch;
    logic             cond_ok;
    logic [XLEN-1:0]  seq_pc;
    logic [XLEN-1:0]  br_pc;
    logic [XLEN-1:0]  rgn_pc;
    logic             lk_we;
    logic [RIDX_W-1:0] lk_idx;
    logic [XLEN-1:0]  lk_data;
    npc_src_e         src;
    npc_state_t       st_d, st_q;

    assign op_dec = npc_decode(op);

    npc_cond #(.XLEN(XLEN)) u_cond (
        .op        (op_dec),
        .opa       (opa),
        .opb       (opb),
        .is_branch (is_branch),
        .cond_ok   (cond_ok)
    );

    npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W), .STEP(STEP)) u_tgt (
        .pc      (cur_pc),
        .br_off  (br_off),
        .jmp_idx (jmp_idx),
        .seq_pc  (seq_pc),
        .br_pc   (br_pc),
        .rgn_pc  (rgn_pc)
    );

    npc_link #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)) u_link (
        .op     (op_dec),
        .seq_pc (seq_pc),
        .we     (lk_we),
        .idx    (lk_idx),
        .data   (lk_data)
    );

    // Source selection: branches only leave the sequential path when the
    // compare holds; all jump forms always leave it.
    always_comb begin
        unique case (op_dec)
            NPC_BEQ, NPC_BNE, NPC_BLEZ, NPC_BGTZ:
                src = (is_branch && cond_ok) ? SRC_BR : SRC_SEQ;
            NPC_JMP, NPC_JAL:   src = SRC_RGN;
            NPC_JR,  NPC_JALR:  src = SRC_REG;
            default:            src = SRC_SEQ;
        endcase
    end

    always_comb begin
        st_d = st_q;
        unique case (src)
            SRC_BR:  st_d.pc = br_pc;
            SRC_RGN: st_d.pc = rgn_pc;
            SRC_REG: st_d.pc = opa;
            default: st_d.pc = seq_pc;
        endcase
        st_d.taken     = (src != SRC_SEQ);
        st_d.link_we   = lk_we;
        st_d.link_idx  = lk_idx;
        st_d.link_data = lk_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc        <= XLEN'(RESET_PC);
            st_q.taken     <= 1'b0;
            st_q.link_we   <= 1'b0;
            st_q.link_idx  <= '0;
            st_q.link_data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nxt_pc    = st_q.pc;
    assign taken     = st_q.taken;
    assign link_we   = st_q.link_we;
    assign link_idx  = st_q.link_idx;
    assign link_data = st_q.link_data;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int OFF_W    = 16,
    parameter int IDX_W    = 26,
    parameter int STEP     = 4,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   cur_pc,
    input logic [OFF_W-1:0]  br_off,
    input logic [IDX_W-1:0]  jmp_idx,
    input logic [XLEN-1:0]   opa,
    input logic [XLEN-1:0]   opb,
    input logic [3:0]        op,
    input logic [XLEN-1:0]   nxt_pc,
    input logic              taken,
    input logic              link_we,
    input logic [RIDX_W-1:0] link_idx,
    input logic [XLEN-1:0]   link_data
);
    localparam int SH    = $clog2(STEP);
    localparam int RGN_W = XLEN - IDX_W - SH;

    logic            armed;
    logic [XLEN-1:0] seq_now;
    logic            eq_now;

    assign seq_now = cur_pc + XLEN'(STEP);
    assign eq_now  = (opa == opb);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !taken |-> nxt_pc == $past(seq_now));

    assert_link_value_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        link_we |-> (link_data == $past(seq_now)) && (link_idx == RIDX_W'(LINK_REG)));

    assert_link_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !link_we |-> (link_data == '0) && (link_idx == '0));

    assert_link_forms_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        link_we |-> taken && (($past(op) == 4'd6) || ($past(op) == 4'd8)));

    assert_reg_target_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (($past(op) == 4'd7) || ($past(op) == 4'd8)) |-> taken && (nxt_pc == $past(opa)));

    assert_region_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (($past(op) == 4'd5) || ($past(op) == 4'd6)) |->
            taken && (nxt_pc[XLEN-1 -: RGN_W] == $past(seq_now[XLEN-1 -: RGN_W]))
                  && (nxt_pc[SH-1:0] == '0));

    assert_beq_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (($past(op) == 4'd1) && $past(eq_now)) |-> taken);

    assert_unused_code_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op) > 4'd8) |-> !taken && !link_we);

endmodule

bind npc_unit npc_unit_chk #(
    .XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W), .STEP(STEP),
    .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .br_off(br_off),
    .jmp_idx(jmp_idx), .opa(opa), .opb(opb), .op(op),
    .nxt_pc(nxt_pc), .taken(taken), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_idx = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [3:0]  op = '0;
    logic [31:0] nxt_pc;
    logic        taken;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    npc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .br_off(br_off),
        .jmp_idx(jmp_idx), .opa(opa), .opb(opb), .op(op),
        .nxt_pc(nxt_pc), .taken(taken), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data)
    );

    // Expected value, computed from the requirements:
    // {pc, taken, link_we, link_idx, link_data}
    function automatic logic [70:0] model(input logic [31:0] pc, input logic [15:0] off,
                                          input logic [25:0] idx, input logic [31:0] a,
                                          input logic [31:0] b, input logic [3:0] c);
        logic [31:0] s, t;
        logic tk, lw;
        s  = pc + 32'd4;
        t  = s;
        tk = 1'b0;
        lw = 1'b0;
        case (c)
            4'd1: tk = (a == b);
            4'd2: tk = (a != b);
            4'd3: tk = ($signed(a) <= 0);
            4'd4: tk = ($signed(a) > 0);
            4'd5, 4'd6: begin tk = 1'b1; t = {s[31:28], idx, 2'b00}; end
            4'd7, 4'd8: begin tk = 1'b1; t = a; end
            default: ;
        endcase
        if (c >= 4'd1 && c <= 4'd4 && tk) t = s + {{14{off[15]}}, off, 2'b00};
        lw = (c == 4'd6) || (c == 4'd8);
        return {t, tk, lw, lw ? 5'd31 : 5'd0, lw ? s : 32'd0};
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd1, 4'd2: return "R4";
            4'd3, 4'd4: return "R5";
            4'd5, 4'd6: return "R7";
            4'd7, 4'd8: return "R8";
            default:    return "R3";
        endcase
    endfunction

    task automatic compare(input string req, input logic [70:0] exp);
        logic [70:0] act;
        act = {nxt_pc, taken, link_we, link_idx, link_data};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual pc=%h tk=%b lw=%b li=%0d ld=%h expected pc=%h tk=%b lw=%b li=%0d ld=%h",
                     req, act[70:39], act[38], act[37], act[36:32], act[31:0],
                     exp[70:39], exp[38], exp[37], exp[36:32], exp[31:0]);
        end
    endtask

    // Drive at a falling edge, capture on the rising edge, check at the next falling edge (R2)
    task automatic apply(input logic [31:0] pc, input logic [15:0] off, input logic [25:0] idx,
                         input logic [31:0] a, input logic [31:0] b, input logic [3:0] c,
                         input string req);
        @(negedge clk);
        cur_pc = pc; br_off = off; jmp_idx = idx; opa = a; opb = b; op = c;
        @(negedge clk);
        compare(req, model(pc, off, idx, a, b, c));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    function automatic logic [31:0] pick_operand();
        case ($urandom % 6)
            0: return 32'd0;
            1: return 32'h7FFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'hFFFF_FFFF;
            4: return 32'd1;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset values while in reset, with live inputs applied
        cur_pc = 32'h1234_5678; op = 4'd6; opa = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        compare("R1", 71'd0);
        rst_n = 1'b1;

        // R3 sequential and unused codes
        apply(32'h0000_1000, 16'h0010, 26'h0, 32'd5, 32'd5, 4'd0, "R3");
        apply(32'h0000_2000, 16'h0010, 26'h3, 32'd7, 32'd7, 4'd15, "R3");
        // R4 equal / not equal, both outcomes
        apply(32'h0000_3000, 16'h0004, 26'h0, 32'hAAAA_0000, 32'hAAAA_0000, 4'd1, "R4");
        apply(32'h0000_3000, 16'h0004, 26'h0, 32'hAAAA_0000, 32'hAAAA_0001, 4'd1, "R4");
        apply(32'h0000_3000, 16'h0004, 26'h0, 32'hAAAA_0000, 32'hAAAA_0001, 4'd2, "R4");
        // R5 signed zero compares, opb varied to show it is ignored
        apply(32'h0000_4000, 16'h0008, 26'h0, 32'd0, 32'd99, 4'd3, "R5");
        apply(32'h0000_4000, 16'h0008, 26'h0, 32'h8000_0000, 32'h8000_0000, 4'd3, "R5");
        apply(32'h0000_4000, 16'h0008, 26'h0, 32'd0, 32'hFFFF_FFFF, 4'd4, "R5");
        apply(32'h0000_4000, 16'h0008, 26'h0, 32'h7FFF_FFFF, 32'd0, 4'd4, "R5");
        // R6 negative and extreme displacements
        apply(32'h0000_5000, 16'hFFFF, 26'h0, 32'd1, 32'd1, 4'd1, "R6");
        apply(32'h0001_0000, 16'h8000, 26'h0, 32'd1, 32'd2, 4'd2, "R6");
        apply(32'h0001_0000, 16'h7FFF, 26'h0, 32'd1, 32'd1, 4'd2, "R6");
        // R7 region comes from PC+4: crossing into the next region
        apply(32'h1FFF_FFFC, 16'h0, 26'h3FF_FFFF, 32'd0, 32'd0, 4'd5, "R7");
        apply(32'hF000_0010, 16'h0, 26'h000_0001, 32'd0, 32'd0, 4'd6, "R7");
        // R8 register target with unaligned low bits
        apply(32'h0000_6000, 16'h0, 26'h0, 32'h1234_5673, 32'd0, 4'd7, "R8");
        // R9 link forms and a non-link jump
        apply(32'h0000_7000, 16'h0, 26'h0, 32'h0000_0040, 32'd0, 4'd8, "R9");
        apply(32'h0000_7000, 16'h0, 26'h15, 32'd0, 32'd0, 4'd6, "R9");
        apply(32'h0000_7000, 16'h0, 26'h0, 32'h0000_0040, 32'd0, 4'd7, "R9");
        // R10 wraparound
        apply(32'hFFFF_FFFC, 16'h0, 26'h0, 32'd0, 32'd0, 4'd0, "R10");
        apply(32'hFFFF_FFFC, 16'h0, 26'h0, 32'd0, 32'd0, 4'd8, "R10");
        apply(32'hFFFF_FFF8, 16'h0002, 26'h0, 32'd3, 32'd3, 4'd1, "R10");

        // Random mix (R2 latency on every vector)
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            logic [3:0]  c;
            a = pick_operand();
            b = (($urandom % 4) == 0) ? a : pick_operand();
            c = 4'($urandom % 16);
            apply($urandom, 16'($urandom), 26'($urandom), a, b, c, tag_of(c));
        end

        // R1 again: asynchronous reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        compare("R1", 71'd0);
        finish_run();
    end

endmodule